// File: doc/BRIEF.md
# Power Mode Transition Controller

This block tracks which of five CPU power modes is in force and works out the next mode each time the core executes a sleep instruction. Three of the modes keep the program running: full-speed active, divided-clock active and subclock active. Two of them halt it: sleep and watch. A single sleep strobe can halt the core. It can also pass through one of the halted modes and land in a different running mode. Which of the two happens depends on a transfer-enable bit, the transfer interrupt enable and the global interrupt mask. When the core lands in a new running mode, the block raises a transfer interrupt request and holds it until it is acknowledged.

The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status level. The only exceptions are two single-cycle pulses: the sleep strobe and the acknowledge. The core drives the control bits and holds them steady around the strobe. The block drives a clock-select code for the clock generator. It also exposes its settling counter, so the wait after a subclock-to-full-speed move can be observed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 5'b00001 (full-speed active), `clk_sel_o` is 0, `settle_cnt_o` is 0 and `xfer_irq_o` is 0.
- R2: Consider a sleep strobe in full-speed mode with stby=0, lspd=0, mspd=1, transfer enable=1, interrupt enable=1 and mask=0. On the next cycle `mode_o` shows sleep (bit 3) for exactly one cycle. After that it shows divided-clock active (bit 1) and `xfer_irq_o` is 1.
- R3: Consider a sleep strobe in divided-clock mode with stby=0, lspd=0, mspd=0, transfer enable=1, interrupt enable=1 and mask=0. The mode shows sleep for one cycle and then full-speed (bit 0), and the request is raised.
- R4: Consider a sleep strobe in full-speed mode with stby=1, lspd=1, subclock-timer select=1, transfer enable=1, interrupt enable=1 and mask=0. The mode shows watch (bit 4) for one cycle and then subclock active (bit 2), and the request is raised.
- R5: Consider a sleep strobe in subclock mode with stby=1, lspd=0, mspd=0, subclock-timer select=1, transfer enable=1, interrupt enable=1 and mask=0. The counter loads 8·2^sel on entry to watch and drops by one each cycle. Watch lasts 8·2^sel+1 cycles, and then the mode becomes full-speed with the request raised.
- R6: If the transfer interrupt enable is 0, a strobe that would otherwise transfer only halts the core. It goes to watch when stby=1 and to sleep otherwise, and no request is raised.
- R7: A strobe with transfer enable=1 and mask=1 halts the core for good. Wake pulses and strobes have no effect, and only reset leaves that state.
- R8: In an ordinary halt, a wake pulse with mask=1 is ignored. A wake pulse with mask=0 returns the core on the next cycle to the running mode it left.
- R9: `xfer_irq_o` stays 1 until a cycle with `irq_ack_i`=1 clears it. A landing in the same cycle as the acknowledge leaves it set.
- R10: A sleep strobe has no effect while the core is halted. A running mode changes only on a sleep strobe.
- R11: `clk_sel_o` is 0 in full-speed, 1 in divided-clock, 2 in subclock active and 3 in sleep or watch.
- R12: `mode_o` always has exactly one bit set. Bit 0 is full-speed, bit 1 divided-clock, bit 2 subclock, bit 3 sleep and bit 4 watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_exec_i | input | 1 | One-cycle pulse: sleep instruction executed |
| stby_i | input | 1 | Standby select (halt kind is watch when 1) |
| lspd_i | input | 1 | Low-speed (subclock) select |
| mspd_i | input | 1 | Divided-clock select |
| xfer_en_i | input | 1 | Direct-transfer enable |
| subtmr_i | input | 1 | Subclock timer select |
| xfer_ie_i | input | 1 | Transfer interrupt enable |
| imask_i | input | 1 | Global interrupt mask |
| wake_i | input | 1 | Wake interrupt from an ordinary halt |
| settle_sel_i | input | SEL_W | Settling time code |
| irq_ack_i | input | 1 | Clears the transfer request |
| mode_o | output | 5 | One-hot current mode |
| clk_sel_o | output | 2 | Clock source code |
| settle_cnt_o | output | BASE_LOG2+2^SEL_W | Settling counter |
| xfer_irq_o | output | 1 | Transfer interrupt request |

## Verification
The hardest cases to reach are the moves that start in divided-clock or subclock mode. Those modes exist only after an earlier transfer has completed, so each sweep case first drives a known transfer out of reset, acknowledges it, and only then applies every combination of the seven control bits. The slow subclock-to-full-speed move is then timed for every settling code. The permanent halt is probed with wake pulses and strobes that would release an ordinary halt.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int NMODES = 5;

  typedef enum logic [2:0] {
    M_HIGH  = 3'd0,
    M_MED   = 3'd1,
    M_SUB   = 3'd2,
    M_SLEEP = 3'd3,
    M_WATCH = 3'd4
  } mode_e;

  // outcome of a sleep strobe taken in a running mode
  typedef struct packed {
    mode_e halt;   // intermediate halted mode
    mode_e dest;   // landing mode when transferring
    logic  xfer;   // completes a transfer
    logic  lock;   // halt that only reset can leave
    logic  slow;   // wait on the settling counter
  } plan_t;

endpackage

// File: rtl/pmc_decide.sv
module pmc_decide
  import pwr_mode_pkg::*;
(
  input  mode_e cur_i,
  input  logic  stby_i,
  input  logic  lspd_i,
  input  logic  mspd_i,
  input  logic  xfer_en_i,
  input  logic  subtmr_i,
  input  logic  xfer_ie_i,
  input  logic  imask_i,
  output plan_t plan_o
);

  logic  legal;
  logic  slow_path;
  mode_e dest;

  always_comb begin
    legal     = 1'b0;
    slow_path = 1'b0;
    dest      = cur_i;
    unique case (cur_i)
      M_HIGH: begin
        if (!stby_i && !lspd_i && mspd_i) begin
          legal = 1'b1;
          dest  = M_MED;
        end else if (stby_i && lspd_i && subtmr_i) begin
          legal = 1'b1;
          dest  = M_SUB;
        end
      end
      M_MED: begin
        if (!stby_i && !lspd_i && !mspd_i) begin
          legal = 1'b1;
          dest  = M_HIGH;
        end
      end
      M_SUB: begin
        if (stby_i && !lspd_i && !mspd_i && subtmr_i) begin
          legal     = 1'b1;
          slow_path = 1'b1;
          dest      = M_HIGH;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    plan_o.halt = stby_i ? M_WATCH : M_SLEEP;
    plan_o.dest = dest;
    plan_o.lock = xfer_en_i & imask_i;
    plan_o.xfer = xfer_en_i & legal & xfer_ie_i & ~imask_i;
    plan_o.slow = plan_o.xfer & slow_path;
  end

endmodule

// File: rtl/pmc_settle.sv
module pmc_settle #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 3,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = {{(CNT_W-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pmc_irq.sv
module pmc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else if (set_i) begin
      irq_q <= 1'b1;
    end else if (ack_i) begin
      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 3
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  sleep_exec_i,
  input  logic                                  stby_i,
  input  logic                                  lspd_i,
  input  logic                                  mspd_i,
  input  logic                                  xfer_en_i,
  input  logic                                  subtmr_i,
  input  logic                                  xfer_ie_i,
  input  logic                                  imask_i,
  input  logic                                  wake_i,
  input  logic [SEL_W-1:0]                      settle_sel_i,
  input  logic                                  irq_ack_i,
  output logic [NMODES-1:0]                     mode_o,
  output logic [1:0]                            clk_sel_o,
  output logic [BASE_LOG2+(1<<SEL_W)-1:0]       settle_cnt_o,
  output logic                                  xfer_irq_o
);

  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

  mode_e cur_q, cur_d;
  mode_e ret_q, ret_d;
  logic  xfer_q, xfer_d;
  logic  lock_q, lock_d;
  logic  slow_q, slow_d;
  logic  running;
  logic  load_cnt;
  logic  land;
  logic  cnt_zero;
  plan_t plan;

  pmc_decide u_decide (
    .cur_i     (cur_q),
    .stby_i    (stby_i),
    .lspd_i    (lspd_i),
    .mspd_i    (mspd_i),
    .xfer_en_i (xfer_en_i),
    .subtmr_i  (subtmr_i),
    .xfer_ie_i (xfer_ie_i),
    .imask_i   (imask_i),
    .plan_o    (plan)
  );

  pmc_settle #(
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2),
    .CNT_W     (CNT_W)
  ) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_cnt),
    .sel_i  (settle_sel_i),
    .cnt_o  (settle_cnt_o),
    .zero_o (cnt_zero)
  );

  pmc_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (land),
    .ack_i  (irq_ack_i),
    .irq_o  (xfer_irq_o)
  );

  assign running = (cur_q == M_HIGH) || (cur_q == M_MED) || (cur_q == M_SUB);

  always_comb begin
    cur_d    = cur_q;
    ret_d    = ret_q;
    xfer_d   = xfer_q;
    lock_d   = lock_q;
    slow_d   = slow_q;
    load_cnt = 1'b0;
    land     = 1'b0;
    if (running) begin
      if (sleep_exec_i) begin
        cur_d    = plan.halt;
        ret_d    = plan.xfer ? plan.dest : cur_q;
        xfer_d   = plan.xfer;
        lock_d   = plan.lock;
        slow_d   = plan.slow;
        load_cnt = plan.slow;
      end
    end else if (!lock_q) begin
      if (xfer_q) begin
        if (!slow_q || cnt_zero) begin
          cur_d  = ret_q;
          xfer_d = 1'b0;
          slow_d = 1'b0;
          land   = 1'b1;
        end
      end else if (wake_i && !imask_i) begin
        cur_d = ret_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= M_HIGH;
      ret_q  <= M_HIGH;
      xfer_q <= 1'b0;
      lock_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      ret_q  <= ret_d;
      xfer_q <= xfer_d;
      lock_q <= lock_d;
      slow_q <= slow_d;
    end
  end

  generate
    for (genvar g = 0; g < NMODES; g++) begin : g_onehot
      assign mode_o[g] = (cur_q == mode_e'(g));
    end
  endgenerate

  always_comb begin
    unique case (cur_q)
      M_HIGH:  clk_sel_o = 2'd0;
      M_MED:   clk_sel_o = 2'd1;
      M_SUB:   clk_sel_o = 2'd2;
      default: clk_sel_o = 2'd3;
    endcase
  end

endmodule

// File: rtl/pmc_checks.sv
module pmc_checks #(
  parameter int CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_exec_i,
  input logic             irq_ack_i,
  input logic [4:0]       mode_o,
  input logic [CNT_W-1:0] settle_cnt_o,
  input logic             xfer_irq_o,
  input logic             lock_q
);

  p_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_irq_o && !irq_ack_i) |=> xfer_irq_o);

  p_irq_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_irq_o) |-> (mode_o[2:0] != 3'b000));

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_cnt_o != '0) |=> (settle_cnt_o == $past(settle_cnt_o) - 1'b1));

  p_cnt_in_watch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settle_cnt_o != '0) |-> mode_o[4]);

  p_lock_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(mode_o));

  p_run_needs_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o[2:0] != 3'b000) && !sleep_exec_i) |=> $stable(mode_o));

endmodule

bind pwr_mode_ctrl pmc_checks #(.CNT_W(CNT_W)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_exec_i (sleep_exec_i),
  .irq_ack_i    (irq_ack_i),
  .mode_o       (mode_o),
  .settle_cnt_o (settle_cnt_o),
  .xfer_irq_o   (xfer_irq_o),
  .lock_q       (lock_q)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int SEL_W = 3;
  localparam int BASE_LOG2 = 3;
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);
  localparam int HI = 0, MED = 1, SUB = 2, SLP = 3, WCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_exec, stby, lspd, mspd, xen, subt, ie, mask, wake, ack;
  logic [SEL_W-1:0] sel;
  logic [4:0] mode;
  logic [1:0] clk_sel;
  logic [CNT_W-1:0] cnt;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_exec_i(sleep_exec), .stby_i(stby),
    .lspd_i(lspd), .mspd_i(mspd), .xfer_en_i(xen), .subtmr_i(subt),
    .xfer_ie_i(ie), .imask_i(mask), .wake_i(wake), .settle_sel_i(sel),
    .irq_ack_i(ack), .mode_o(mode), .clk_sel_o(clk_sel),
    .settle_cnt_o(cnt), .xfer_irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_bits(input logic [6:0] b);
    {mask, ie, subt, xen, mspd, lspd, stby} = b;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sleep_exec = 0; wake = 0; ack = 0; sel = '0;
    set_bits(7'd0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic strobe();
    sleep_exec = 1'b1;
    tick();
    sleep_exec = 1'b0;
  endtask

  // bits order: {mask, ie, subt, xen, mspd, lspd, stby}
  task automatic goto_start(input int s);
    if (s == MED) begin
      set_bits(7'b0101100); strobe(); tick();
    end else if (s == SUB) begin
      set_bits(7'b0111011); strobe(); tick();
    end
    if (s != HI) begin
      ack = 1'b1; tick(); ack = 1'b0;
    end
    set_bits(7'd0);
  endtask

  function automatic int exp_clk(input int m);
    return (m <= SUB) ? m : 3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 mode", int'(mode), 1);
    chk("R1 clk_sel", int'(clk_sel), 0);
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 irq", int'(irq), 0);

    // near-exhaustive sweep: three start modes x all control combinations
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 128; c++) begin
        logic [6:0] b;
        logic legal, slow, is_x, is_lock;
        int kind, dest;
        string rq;
        b = 7'(c);
        do_reset();
        goto_start(s);
        chk("R11 start", int'(clk_sel), exp_clk(s));
        set_bits(b);
        legal = 0; slow = 0; dest = s;
        if (s == HI && !b[0] && !b[1] && b[2]) begin legal = 1; dest = MED; end
        else if (s == HI && b[0] && b[1] && b[4]) begin legal = 1; dest = SUB; end
        else if (s == MED && !b[0] && !b[1] && !b[2]) begin legal = 1; dest = HI; end
        else if (s == SUB && b[0] && !b[1] && !b[2] && b[4]) begin legal = 1; dest = HI; slow = 1; end
        kind = b[0] ? WCH : SLP;
        is_x = b[3] && legal && b[5] && !b[6];
        is_lock = b[3] && b[6];
        strobe();
        chk("R6 halt kind", int'(mode), 1 << kind);
        chk("R11 halted", int'(clk_sel), 3);
        if (is_x) begin
          rq = (dest == MED) ? "R2" : (dest == SUB) ? "R4" : (slow ? "R5" : "R3");
          if (slow) begin
            chk("R5 load", int'(cnt), 8);
            repeat (8) tick();
            chk("R5 still watch", int'(mode), 1 << WCH);
            chk("R5 cnt zero", int'(cnt), 0);
          end
          tick();
          chk({rq, " landed"}, int'(mode), 1 << dest);
          chk({rq, " irq"}, int'(irq), 1);
          chk("R11 landed", int'(clk_sel), exp_clk(dest));
        end else if (is_lock) begin
          mask = 1'b0; wake = 1'b1; sleep_exec = 1'b1;
          repeat (3) tick();
          wake = 1'b0; sleep_exec = 1'b0;
          tick();
          chk("R7 locked", int'(mode), 1 << kind);
          chk("R7 no irq", int'(irq), 0);
        end else begin
          rq = (b[3] && legal && !b[5]) ? "R6" : "R8";
          mask = 1'b1; wake = 1'b1; tick(); wake = 1'b0;
          chk("R8 masked wake", int'(mode), 1 << kind);
          sleep_exec = 1'b1; tick(); sleep_exec = 1'b0;
          chk("R10 strobe while halted", int'(mode), 1 << kind);
          mask = 1'b0; wake = 1'b1; tick(); wake = 1'b0;
          chk({rq, " wake return"}, int'(mode), 1 << s);
          chk({rq, " no irq"}, int'(irq), 0);
        end
      end
    end

    // R5: settling length for every code
    for (int k = 0; k < (1 << SEL_W); k++) begin
      int n;
      do_reset();
      goto_start(SUB);
      sel = SEL_W'(k);
      set_bits(7'b0111001);
      strobe();
      chk("R5 load value", int'(cnt), 8 << k);
      n = 1;
      while (mode == 5'(1 << WCH) && n < 3000) begin
        tick();
        if (mode == 5'(1 << WCH)) n++;
      end
      chk("R5 watch length", n, (8 << k) + 1);
      chk("R5 final mode", int'(mode), 1 << HI);
    end

    // R9: hold until ack; set wins over ack
    do_reset();
    set_bits(7'b0101100); strobe(); tick();
    repeat (5) tick();
    chk("R9 hold", int'(irq), 1);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R9 cleared", int'(irq), 0);
    set_bits(7'b0101100); mspd = 1'b0; strobe();
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R9 set beats ack", int'(irq), 1);
    chk("R3 back to high", int'(mode), 1 << HI);

    // R10: running mode unchanged without strobe
    repeat (4) tick();
    chk("R10 stable", int'(mode), 1 << HI);
    chk("R12 onehot", $countones(mode), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule